// File: doc/BRIEF.md
# SMRAM Access Router with Configuration Lock

This block sits in front of a memory controller and decides, for every memory request, whether it goes to DRAM, goes to the legacy video buffer, or is rejected. It holds four configuration words:

- a control word with the global SMRAM enable, the open override and the lock;
- a segment word with the top-segment enable and its size code;
- the top of usable low memory;
- the amount of memory taken by integrated graphics.

Each request carries a 32-bit address, a flag saying whether the requester is in system management mode, and a flag saying whether it comes from the processor or from another bus agent.

Two address ranges are special. The first is the fixed legacy video window. The second is a protected segment placed just below the graphics carve-out: it ends at top-of-memory minus the graphics size and extends downward by the coded segment size. Addresses outside both ranges always go to DRAM.

Firmware programs the words and may set the open override while it installs handler code. It then sets the lock. From that point until reset, every configuration word is frozen and the override stays off. Every request receives exactly one registered response on the following cycle.

Top module: `smram_route_dec`

## Requirements
- R1: After reset every configuration word reads 0, and `rsp_valid`, `rsp_route`, `rsp_err` and `rsp_data` are 0.
- R2: A write with `cfg_sel` 0 stores the control word, which keeps only bit 3 (global enable), bit 4 (lock) and bit 6 (open). `cfg_sel` 1 stores the segment word, which keeps only bit 0 (segment enable) and bits 2:1 (size code); bit 7 and all other bits read 0. `cfg_sel` 2 stores the top of memory and `cfg_sel` 3 stores the graphics size, each as a full 32-bit word. `cfg_rdata` shows the word chosen by `cfg_sel` in the same cycle.
- R3: While the global enable is 1, a processor request in system management mode to 0x000A_0000..0x000B_FFFF gets route 2'b01 (DRAM). Any other request to that window gets route 2'b10 (video), unless R8 applies.
- R4: While the global enable is 0, every request to 0x000A_0000..0x000B_FFFF gets route 2'b10, regardless of mode, source or override.
- R5: The protected segment covers addresses A with (top − graphics − size) ≤ A < (top − graphics), using 32-bit arithmetic. Size code 0 means 1 MB, code 1 means 2 MB, code 2 means 8 MB. Code 3 is reserved and disables the segment.
- R6: For an address in an active segment:
  - a processor request in system management mode gets route 2'b01;
  - a processor request outside that mode, with the override off, gets route 2'b11 (reject);
  - a request from any other agent always gets route 2'b11.
- R7: While the global enable is 0, the segment is inactive and its addresses get route 2'b01, even when the segment enable is 1.
- R8: While the open override is 1, processor requests outside system management mode get route 2'b01 in both the active segment and the enabled video window. Requests from other agents are not affected.
- R9: Writing the control word with bit 4 set locks the block and clears the override in the same write. While locked, writes to all four words are ignored until reset.
- R10: For each rejected request, `rsp_err` is 1 for exactly the response cycle and `rsp_data` is all-ones. For every other response both are 0.
- R11: A request sampled at a rising edge produces `rsp_valid` = 1 with its route after that edge, for one cycle. With no request, `rsp_valid` is 0 and `rsp_route` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select (0 control, 1 segment, 2 top of memory, 3 graphics size) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected configuration word |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request physical address |
| req_smm | input | 1 | Requester is in system management mode |
| req_cpu | input | 1 | Request comes from the processor (0: other agent) |
| rsp_valid | output | 1 | Response present |
| rsp_route | output | 2 | 01 DRAM, 10 video, 11 reject, 00 idle |
| rsp_err | output | 1 | One-cycle error flag for a rejected request |
| rsp_data | output | 32 | All-ones fill data for a rejected request, else 0 |

## Verification
A wrong configuration bit shows up on `cfg_rdata` combinationally, and in the route of the next request that falls into the video window or the segment. A lock that drops or an override that survives the lock shows up one cycle after the next segment request from outside system management mode: that request is sent to DRAM instead of being rejected. A wrong bound in the segment arithmetic only appears for addresses at the edges. For that reason the stimulus concentrates addresses one below, at, and just inside both segment edges, across all four size codes and several graphics sizes.

// File: rtl/smram_route_dec.sv
module smram_route_dec #(
  parameter int AW    = 32,
  parameter int MB_LG = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cfg_rdata,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_smm,
  input  logic          req_cpu,
  output logic          rsp_valid,
  output logic [1:0]    rsp_route,
  output logic          rsp_err,
  output logic [AW-1:0] rsp_data
);

  localparam logic [1:0] RT_IDLE = 2'b00;
  localparam logic [1:0] RT_DRAM = 2'b01;
  localparam logic [1:0] RT_VGA  = 2'b10;
  localparam logic [1:0] RT_REJ  = 2'b11;
  localparam logic [AW-1:0] VGA_LO = AW'(32'h000A_0000);
  localparam logic [AW-1:0] VGA_HI = AW'(32'h000B_FFFF);
  localparam logic [AW-1:0] ONE_MB = AW'(1) << MB_LG;

  logic          g_en, lock, open_q, seg_en;
  logic [1:0]    seg_code;
  logic [AW-1:0] tolud_q, stolen_q;
  logic [AW-1:0] seg_size, seg_top, seg_base;
  logic          seg_live, in_seg, in_vga, priv;
  logic [1:0]    route_d;

  wire wr_ok = cfg_we & ~lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_en     <= 1'b0;
      lock     <= 1'b0;
      open_q   <= 1'b0;
      seg_en   <= 1'b0;
      seg_code <= 2'b00;
      tolud_q  <= '0;
      stolen_q <= '0;
    end else if (wr_ok) begin
      case (cfg_sel)
        2'd0: begin
          g_en   <= cfg_wdata[3];
          lock   <= cfg_wdata[4];
          open_q <= cfg_wdata[6] & ~cfg_wdata[4];
        end
        2'd1: begin
          seg_en   <= cfg_wdata[0];
          seg_code <= cfg_wdata[2:1];
        end
        2'd2: tolud_q  <= cfg_wdata;
        default: stolen_q <= cfg_wdata;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      2'd0: begin
        cfg_rdata[3] = g_en;
        cfg_rdata[4] = lock;
        cfg_rdata[6] = open_q;
      end
      2'd1: cfg_rdata[2:0] = {seg_code, seg_en};
      2'd2: cfg_rdata = tolud_q;
      default: cfg_rdata = stolen_q;
    endcase
  end

  always_comb begin
    case (seg_code)
      2'd0:    seg_size = ONE_MB;
      2'd1:    seg_size = ONE_MB << 1;
      2'd2:    seg_size = ONE_MB << 3;
      default: seg_size = '0;
    endcase
  end

  assign seg_top  = tolud_q - stolen_q;
  assign seg_base = seg_top - seg_size;
  assign seg_live = g_en & seg_en & (seg_code != 2'b11);
  assign in_seg   = seg_live && (req_addr >= seg_base) && (req_addr < seg_top);
  assign in_vga   = (req_addr >= VGA_LO) && (req_addr <= VGA_HI);
  assign priv     = req_smm | open_q;

  always_comb begin
    if (in_seg)
      route_d = (req_cpu && priv) ? RT_DRAM : RT_REJ;
    else if (in_vga)
      route_d = (g_en && req_cpu && priv) ? RT_DRAM : RT_VGA;
    else
      route_d = RT_DRAM;
  end

  wire rej = req_valid && (route_d == RT_REJ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= RT_IDLE;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_route <= req_valid ? route_d : RT_IDLE;
      rsp_err   <= rej;
      rsp_data  <= rej ? '1 : '0;
    end
  end

endmodule

// File: rtl/smram_route_chk.sv
module smram_route_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic          req_valid,
  input logic          rsp_valid,
  input logic [1:0]    rsp_route,
  input logic          rsp_err,
  input logic [AW-1:0] rsp_data,
  input logic          lock,
  input logic          open_q,
  input logic [AW-1:0] tolud_q,
  input logic [AW-1:0] stolen_q
);

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_when_no_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_route == 2'b00));

  assert_err_matches_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err == (rsp_valid && rsp_route == 2'b11));

  assert_fill_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err ? (rsp_data == '1) : (rsp_data == '0));

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);

  assert_lock_no_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !open_q);

  assert_lock_freezes_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && cfg_we) |=> ($stable(tolud_q) && $stable(stolen_q)));

endmodule

bind smram_route_dec smram_route_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
  .rsp_valid(rsp_valid), .rsp_route(rsp_route), .rsp_err(rsp_err),
  .rsp_data(rsp_data), .lock(lock), .open_q(open_q),
  .tolud_q(tolud_q), .stolen_q(stolen_q)
);

// File: tb/test_smram_route_dec.sv
`timescale 1ns/1ps
module test_smram_route_dec;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic req_valid = 1'b0, req_smm = 1'b0, req_cpu = 1'b0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_err;
  logic [1:0] rsp_route;
  logic [31:0] rsp_data;

  int checks = 0, errors = 0;
  logic [7:0]  m_ctrl = '0, m_ext = '0;
  logic [31:0] m_tolud = '0, m_stolen = '0;

  always #4 clk = ~clk;

  smram_route_dec i_smram_route_dec (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_size();
    case (m_ext[2:1])
      2'd0: return 32'h0010_0000;
      2'd1: return 32'h0020_0000;
      2'd2: return 32'h0080_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [1:0] exp_route(input logic [31:0] a, input bit smm, input bit cpu);
    logic [31:0] top, base;
    bit live, ok;
    top  = m_tolud - m_stolen;
    base = top - m_size();
    live = m_ctrl[3] && m_ext[0] && (m_ext[2:1] != 2'b11);
    ok   = smm || m_ctrl[6];
    if (live && a >= base && a < top) return (cpu && ok) ? 2'b01 : 2'b11;
    if (a >= 32'h000A_0000 && a <= 32'h000B_FFFF)
      return (m_ctrl[3] && cpu && ok) ? 2'b01 : 2'b10;
    return 2'b01;
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!m_ctrl[4]) begin
      case (s)
        2'd0: m_ctrl = {1'b0, d[6] & ~d[4], 1'b0, d[4], d[3], 3'b000};
        2'd1: m_ext  = {5'b0, d[2:0]};
        2'd2: m_tolud = d;
        default: m_stolen = d;
      endcase
    end
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] exp, input string tag);
    cfg_sel = s;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic rq(input logic [31:0] a, input bit smm, input bit cpu, input string tag);
    logic [1:0] e;
    e = exp_route(a, smm, cpu);
    req_valid = 1'b1; req_addr = a; req_smm = smm; req_cpu = cpu;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " route"}, {30'b0, rsp_route}, {30'b0, e});
    chk("R11 valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 err", {31'b0, rsp_err}, {31'b0, e == 2'b11});
    chk("R10 data", rsp_data, (e == 2'b11) ? 32'hFFFF_FFFF : 32'h0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog R11 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, top;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 4; s++) rd(2'(s), 32'h0, "R1 cfg reset");
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 rsp_err", {31'b0, rsp_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle route", {30'b0, rsp_route}, 32'd0);

    // R2 write masks
    wr(2'd0, 32'hFFFF_FFAF); rd(2'd0, 32'h08, "R2 ctrl mask");
    wr(2'd0, 32'h0000_004F); rd(2'd0, 32'h48, "R2 ctrl open");
    wr(2'd1, 32'h0000_00FF); rd(2'd1, 32'h07, "R2 seg mask bit7 zero");
    wr(2'd2, 32'hE000_0000); rd(2'd2, 32'hE000_0000, "R2 tolud");
    wr(2'd3, 32'h0000_0000); rd(2'd3, 32'h0, "R2 stolen");

    // R5/R6 1 MB segment at DFF0_0000..DFFF_FFFF
    wr(2'd0, 32'h08); wr(2'd1, 32'h01);
    rq(32'hDFF0_0000, 1, 1, "R6 smm cpu base");
    rq(32'hDFFF_FFFF, 0, 1, "R6 nonsmm cpu top");
    rq(32'hDFEF_FFFF, 0, 1, "R5 below base");
    rq(32'hE000_0000, 0, 1, "R5 at top excluded");
    rq(32'hDFF8_0000, 1, 0, "R6 agent rejected");
    @(negedge clk);
    chk("R10 err one cycle", {31'b0, rsp_err}, 32'd0);
    chk("R11 no req", {31'b0, rsp_valid}, 32'd0);
    wr(2'd1, 32'h03); rq(32'hDFE0_0000, 0, 1, "R5 2MB base"); rq(32'hDFDF_FFFF, 0, 1, "R5 2MB below");
    wr(2'd1, 32'h05); rq(32'hDF80_0000, 0, 1, "R5 8MB base"); rq(32'hDF7F_FFFF, 0, 1, "R5 8MB below");
    wr(2'd1, 32'h07); rq(32'hDFFF_0000, 0, 0, "R5 code3 disabled");
    wr(2'd1, 32'h01); wr(2'd3, 32'h0400_0000);
    rq(32'hDBF0_0000, 0, 1, "R5 stolen base"); rq(32'hDC00_0000, 0, 1, "R5 stolen top");
    // R3 video window
    rq(32'h000A_0000, 1, 1, "R3 smm dram"); rq(32'h000B_FFFF, 0, 1, "R3 nonsmm video");
    rq(32'h000A_8000, 1, 0, "R3 agent video"); rq(32'h000C_0000, 0, 1, "R3 past window");
    // R4/R7 global enable off
    wr(2'd0, 32'h00);
    rq(32'h000A_0000, 1, 1, "R4 genable off"); rq(32'hDBF8_0000, 0, 0, "R7 seg disabled");
    // R8 open
    wr(2'd0, 32'h48);
    rq(32'hDBF8_0000, 0, 1, "R8 open seg"); rq(32'hDBF8_0000, 0, 0, "R8 agent still rejected");
    rq(32'h000B_0000, 0, 1, "R8 open video window");

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      if (i % 64 == 0) begin
        wr(2'd0, $urandom & 32'hFFFF_FFEF);
        wr(2'd1, $urandom);
        wr(2'd2, 32'h8000_0000 + (($urandom % 64) << 22));
        wr(2'd3, ($urandom % 4) << 24);
      end
      top = m_tolud - m_stolen;
      case ($urandom % 4)
        0: a = 32'h000A_0000 + ($urandom % 32'h0002_0000) - 32'h8;
        1: a = top - m_size() + ($urandom % 8) - 4;
        2: a = top + ($urandom % 8) - 4;
        default: a = top - ($urandom % 32'h0100_0000);
      endcase
      rq(a, 1'($urandom), 1'($urandom), "R3 R5 R6 R8 random");
    end

    // R9 lock
    wr(2'd1, 32'h01); wr(2'd2, 32'hE000_0000); wr(2'd3, 32'h0);
    wr(2'd0, 32'h58); rd(2'd0, 32'h18, "R9 lock clears open");
    wr(2'd0, 32'h40); rd(2'd0, 32'h18, "R9 ctrl frozen");
    wr(2'd1, 32'h00); rd(2'd1, 32'h01, "R9 seg frozen");
    wr(2'd2, 32'h1234_0000); rd(2'd2, 32'hE000_0000, "R9 tolud frozen");
    wr(2'd3, 32'h0100_0000); rd(2'd3, 32'h0, "R9 stolen frozen");
    rq(32'hDFF4_0000, 0, 1, "R9 locked nonsmm rejected");
    for (int i = 0; i < 200; i++) begin
      wr(2'($urandom), $urandom);
      rq(32'hDFE0_0000 + ($urandom % 32'h0030_0000), 1'($urandom), 1'($urandom), "R9 locked random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule